// File: doc/BRIEF.md
# SMBus Host Notify Receiver

This block listens on a two-wire SMBus segment for the Host Notify message, a write that an external master sends to a reserved address. The message tells the host which device wants attention and carries a 16-bit word. Both bus lines are resynchronised and deglitched. Start and Stop conditions are recognised. The block acknowledges each byte of a notify frame by pulling SDA low through an open-drain enable, and it ignores all other traffic on the bus.

When a whole frame ends cleanly with a Stop, the block does three things:
- It copies the sender's 7-bit address and the two data bytes into output registers.
- It sets a sticky pending flag.
- It raises an interrupt that follows that flag.

While the flag is set, the block refuses the next notify by leaving the address acknowledge slot high. The data already captured therefore stays intact until software has read it and pulsed the clear input.

Top module: `smbus_notify_rx`

## Requirements
- R1: A first byte of seven address bits 0001000 (sent MSB first) followed by a direction bit of 0 is acknowledged when the pending flag is clear. Acknowledge means that SDA is low while SCL is high in the ninth bit slot.
- R2: If the first byte carries any other address, or a direction bit of 1, no acknowledge slot of that frame is driven low, and the frame changes no output.
- R3: If the pending flag is set when the first byte completes, the address slot is left high. The stored address, the stored data and the flag keep their values.
- R4: In an accepted frame, the upper seven bits of the second byte (MSB first) become `notify_dev_o`. The eighth bit is padding and is ignored. The second, third and fourth bytes are all acknowledged.
- R5: The third byte becomes `notify_lo_o` and the fourth byte becomes `notify_hi_o`.
- R6: The registers and the pending flag change only after a Stop that follows a complete four-byte frame. `irq_o` always equals `pend_o`.
- R7: A Start or a Stop that arrives before the fourth acknowledge slot ends discards the partial frame and keeps the previous outputs. A repeated Start begins a new frame.
- R8: A one-cycle pulse on `clr_i` clears the pending flag on the next clock, and a later notify is then accepted. If a clear and a capture fall in the same cycle, the clear wins.
- R9: After reset, the pending flag, `irq_o`, all captured registers and `sda_oe_o` are 0.
- R10: A pulse on either bus line that is shorter than `FILT_LEN` clock cycles (default 3) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin, including this block's own drive |
| clr_i | input | 1 | Software clear of the pending flag, one-cycle pulse |
| sda_oe_o | output | 1 | When 1, pulls SDA low (open-drain enable) |
| notify_dev_o | output | 7 | Address of the master that sent the last accepted notify |
| notify_lo_o | output | 8 | Low data byte of the last accepted notify |
| notify_hi_o | output | 8 | High data byte of the last accepted notify |
| pend_o | output | 1 | Sticky flag: captured notify not yet serviced |
| irq_o | output | 1 | Interrupt request, equal to the pending flag |

## Verification
The bench sends a second notify while the first is still pending. A design that did not refuse it would overwrite the captured word, or acknowledge the address, and the acknowledge sample or the per-clock register comparison would show it.

Frames with a wrong address, a read direction bit, a Stop after the third byte, or a repeated Start after the second byte are each followed by a check that nothing was captured. A design that committed data before the Stop, or committed partial data, would fail that check.

A one-cycle pulse on SCL during a low phase tests the filter. A design that counted it as a clock edge would shift every following bit and capture corrupted bytes.

// File: rtl/snr_pkg.sv
package snr_pkg;
  localparam int BYTE_W      = 8;
  localparam int ADDR_W      = 7;
  localparam int FRAME_BYTES = 4;
  localparam int IDX_W       = $clog2(FRAME_BYTES);
  localparam int BIT_W       = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_DONE
  } snr_state_e;
endpackage

// File: rtl/snr_line_filter.sv
module snr_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [1:0]       sync_q;
  logic             filt_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
        filt_q <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = filt_q;

  // R10: a new filtered level was already present on the synchronised line two cycles before
  generate
    if (FILT_LEN >= 2) begin : g_chk
      a_r10_filter_settled: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q) |-> ($past(sync_q[1], 2) == filt_q));
    end
  endgenerate
endmodule

// File: rtl/snr_frame_fsm.sv
module snr_frame_fsm
  import snr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] NOTIFY_ADDR = 7'b0001000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic              pend_i,
  output logic              sda_oe_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] dev_o,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o
);
  localparam logic [BYTE_W-1:0] ADDR_BYTE = {NOTIFY_ADDR, 1'b0};
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(FRAME_BYTES - 1);
  localparam logic [BIT_W-1:0]  FULL_CNT  = BIT_W'(BYTE_W);

  snr_state_e        st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BIT_W-1:0]  bits_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              scl_d, sda_d;
  logic              sda_oe_q, commit_q;
  logic [ADDR_W-1:0] dev_q;
  logic [BYTE_W-1:0] lo_q, hi_q;

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      idx_q    <= '0;
      bits_q   <= '0;
      shreg_q  <= '0;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      sda_oe_q <= 1'b0;
      commit_q <= 1'b0;
      dev_q    <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else begin
      scl_d    <= scl_f;
      sda_d    <= sda_f;
      commit_q <= 1'b0;
      if (start_c) begin
        st_q     <= S_RX;
        idx_q    <= '0;
        bits_q   <= '0;
        sda_oe_q <= 1'b0;
      end else if (stop_c) begin
        commit_q <= (st_q == S_DONE);
        st_q     <= S_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        case (st_q)
          S_RX: begin
            if (scl_rise && bits_q != FULL_CNT) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_f};
              bits_q  <= bits_q + 1'b1;
            end else if (scl_fall && bits_q == FULL_CNT) begin
              bits_q <= '0;
              if (idx_q == '0) begin
                if (shreg_q == ADDR_BYTE && !pend_i) begin
                  sda_oe_q <= 1'b1;
                  st_q     <= S_ACK;
                end else begin
                  st_q <= S_IDLE;
                end
              end else begin
                if (idx_q == IDX_W'(1))      dev_q <= shreg_q[BYTE_W-1:1];
                else if (idx_q == IDX_W'(2)) lo_q  <= shreg_q;
                else                         hi_q  <= shreg_q;
                sda_oe_q <= 1'b1;
                st_q     <= S_ACK;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_oe_q <= 1'b0;
              if (idx_q == LAST_IDX) begin
                st_q <= S_DONE;
              end else begin
                idx_q <= idx_q + 1'b1;
                st_q  <= S_RX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = sda_oe_q;
  assign commit_o = commit_q;
  assign dev_o    = dev_q;
  assign lo_o     = lo_q;
  assign hi_o     = hi_q;

  // R1: the line is pulled only inside an acknowledge slot
  a_r1_drive_in_ack: assert property (@(posedge clk) disable iff (rst)
    sda_oe_q |-> (st_q == S_ACK));

  // R3: an address acknowledge never starts while a notify is pending
  a_r3_nack_pending: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe_q) && idx_q == '0) |-> !$past(pend_i));

  // R2: after a refused address the block stays quiet
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_IDLE && !start_c) |=> !sda_oe_q);
endmodule

// File: rtl/smbus_notify_rx.sv
module smbus_notify_rx
  import snr_pkg::*;
#(
  parameter int                FILT_LEN    = 3,
  parameter logic [ADDR_W-1:0] NOTIFY_ADDR = 7'b0001000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              clr_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] notify_dev_o,
  output logic [BYTE_W-1:0] notify_lo_o,
  output logic [BYTE_W-1:0] notify_hi_o,
  output logic              pend_o,
  output logic              irq_o
);
  logic [1:0] raw_lines, filt_lines;
  assign raw_lines = {scl_i, sda_i};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_line
      snr_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .line_i (raw_lines[g]),
        .line_o (filt_lines[g])
      );
    end
  endgenerate

  logic              commit;
  logic [ADDR_W-1:0] dev_h;
  logic [BYTE_W-1:0] lo_h, hi_h;
  logic              pend_q;
  logic [ADDR_W-1:0] dev_q;
  logic [BYTE_W-1:0] lo_q, hi_q;

  snr_frame_fsm #(.NOTIFY_ADDR(NOTIFY_ADDR)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (filt_lines[1]),
    .sda_f    (filt_lines[0]),
    .pend_i   (pend_q),
    .sda_oe_o (sda_oe_o),
    .commit_o (commit),
    .dev_o    (dev_h),
    .lo_o     (lo_h),
    .hi_o     (hi_h)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      dev_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      if (commit) begin
        dev_q <= dev_h;
        lo_q  <= lo_h;
        hi_q  <= hi_h;
      end
      if (clr_i)       pend_q <= 1'b0;
      else if (commit) pend_q <= 1'b1;
    end
  end

  assign notify_dev_o = dev_q;
  assign notify_lo_o  = lo_q;
  assign notify_hi_o  = hi_q;
  assign pend_o       = pend_q;
  assign irq_o        = pend_q;

  // R6: the flag rises only after the sequencer reports a finished frame
  a_r6_set_by_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(commit));

  // R7: captured values hold unless a frame was just committed
  a_r7_regs_hold: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(dev_q) && $stable(lo_q) && $stable(hi_q)));

  // R8: a clear always leaves the flag low on the next clock
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !pend_q);
endmodule

// File: tb/tb_smbus_notify_rx.sv
`timescale 1ns/1ps
module tb_smbus_notify_rx;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic clr = 1'b0;
  logic sda_oe;
  logic [6:0] dev;
  logic [7:0] lo, hi;
  logic pend, irq;
  wire  sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  smbus_notify_rx dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .clr_i(clr),
    .sda_oe_o(sda_oe), .notify_dev_o(dev), .notify_lo_o(lo),
    .notify_hi_o(hi), .pend_o(pend), .irq_o(irq)
  );

  int checks = 0;
  int fails = 0;
  bit chk_en = 1'b0;
  logic [6:0] e_dev = '0;
  logic [7:0] e_lo = '0, e_hi = '0;
  logic e_pend = 1'b0;
  logic rd;

  // per-clock comparison against the behavioural model (R3 R5 R6 R7)
  always @(negedge clk) begin
    if (chk_en) begin
      checks++;
      if (dev !== e_dev || lo !== e_lo || hi !== e_hi || pend !== e_pend || irq !== e_pend) begin
        fails++;
        $display("FAIL R6 outputs dev=%h lo=%h hi=%h pend=%b irq=%b expected %h %h %h %b %b",
                 dev, lo, hi, pend, irq, e_dev, e_lo, e_hi, e_pend, e_pend);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    sda_m = b;
    if (glitch) begin
      tick(Q / 2);
      scl_m = 1'b1; tick(1);
      scl_m = 1'b0; tick(Q / 2);
    end else begin
      tick(Q);
    end
    scl_m = 1'b1; tick(Q);
    rd = sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit exp_ack, input bit glitch,
                           input string tag);
    for (int i = 7; i >= 0; i--) send_bit(v[i], glitch && i == 4);
    send_bit(1'b1, 1'b0);
    checks++;
    if (rd !== !exp_ack) begin
      fails++;
      $display("FAIL %s ack slot sda=%b expected %b", tag, rd, !exp_ack);
    end
  endtask

  task automatic bus_stop(input bit do_commit, input logic [6:0] d,
                          input logic [7:0] l, input logic [7:0] h);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    chk_en = 1'b0;
    sda_m = 1'b1; tick(Q + 12);
    if (do_commit) begin
      e_dev = d; e_lo = l; e_hi = h; e_pend = 1'b1;
    end
    chk_en = 1'b1;
    tick(Q);
  endtask

  task automatic notify(input logic [6:0] ha, input logic rw, input logic [6:0] d,
                        input logic [7:0] l, input logic [7:0] h, input bit glitch,
                        input string tag);
    bit acc;
    acc = (ha == 7'b0001000) && (rw == 1'b0) && !e_pend;
    bus_start();
    send_byte({ha, rw}, acc, 1'b0, tag);
    send_byte({d, 1'b0}, acc, 1'b0, "R4");
    send_byte(l, acc, glitch, "R5");
    send_byte(h, acc, 1'b0, "R5");
    bus_stop(acc, d, l, h);
  endtask

  task automatic do_clear();
    chk_en = 1'b0;
    clr = 1'b1; tick(1);
    clr = 1'b0;
    e_pend = 1'b0;
    tick(2);
    chk_en = 1'b1;
    checks++;
    if (pend !== 1'b0 || irq !== 1'b0) begin
      fails++;
      $display("FAIL R8 pend=%b irq=%b expected 0 0", pend, irq);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    tick(6);
    rst = 1'b0;
    tick(2);
    // R9 reset state
    checks++;
    if (pend !== 1'b0 || irq !== 1'b0 || dev !== 7'd0 || lo !== 8'd0 || hi !== 8'd0 || sda_oe !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset outputs pend=%b dev=%h lo=%h hi=%h oe=%b expected all 0",
               pend, dev, lo, hi, sda_oe);
    end
    chk_en = 1'b1;
    tick(Q);

    // R1 R4 R5 R6 accepted notify
    notify(7'b0001000, 1'b0, 7'h5A, 8'h34, 8'h12, 1'b0, "R1");
    // R3 refused while pending, previous data kept
    notify(7'b0001000, 1'b0, 7'h21, 8'hAA, 8'h55, 1'b0, "R3");
    do_clear(); // R8

    // R2 wrong address and read direction
    notify(7'b0001001, 1'b0, 7'h11, 8'h22, 8'h33, 1'b0, "R2");
    notify(7'b0001000, 1'b1, 7'h11, 8'h22, 8'h33, 1'b0, "R2");
    notify(7'b1110111, 1'b0, 7'h11, 8'h22, 8'h33, 1'b0, "R2");

    // R7 stop after the third byte: nothing committed
    bus_start();
    send_byte(8'h10, 1'b1, 1'b0, "R7");
    send_byte(8'hCE, 1'b1, 1'b0, "R7");
    send_byte(8'h99, 1'b1, 1'b0, "R7");
    bus_stop(1'b0, 7'd0, 8'd0, 8'd0);

    // R7 repeated start after the second byte, then a full frame
    bus_start();
    send_byte(8'h10, 1'b1, 1'b0, "R7");
    send_byte(8'h6C, 1'b1, 1'b0, "R7");
    notify(7'b0001000, 1'b0, 7'h3C, 8'hC3, 8'h0F, 1'b0, "R7");

    do_clear(); // R8 then accept again
    // R10 single-cycle SCL glitch inside the low data byte
    notify(7'b0001000, 1'b0, 7'h7F, 8'hFF, 8'h00, 1'b1, "R10");
    do_clear();
    notify(7'b0001000, 1'b0, 7'h00, 8'h00, 8'hFF, 1'b0, "R5");
    do_clear();
    notify(7'b0001000, 1'b0, 7'h2B, 8'h81, 8'h7E, 1'b0, "R4");

    tick(Q);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule